// File: doc/BRIEF.md
# Power-Fail RAM Chip-Enable Controller

This block sits between an address decoder's active-low chip-enable and a static RAM that is kept alive by one or two backup batteries. It gates the chip-enable so the RAM cannot be touched while the main supply is out of tolerance. When the supply fails, an access that is already running is allowed to finish. After the supply returns, the RAM stays locked for a recovery interval. The block also chooses whether the RAM is powered from the main supply, from one of the two batteries, or from nothing.

Every analog decision arrives as a digital flag from external comparators. These flags are: supply within tolerance, each battery present, each battery low, battery 1 stronger than battery 2, and supply above the selected battery. Each flag passes through a two-flop synchronizer before any state decision uses it. A tolerance-select input is passed straight through to the comparator that sets the trip window. A storage seal keeps both batteries isolated until the supply first comes up. A low battery is reported to software by suppressing the second RAM access after recovery, so a write-then-read-back test fails.

Top module: `nvc_ce_guard`

## Requirements
- R1: After reset, `ce_out_n` is high, `pwr_sel` is 4'b1000 (no source) and `sealed` is low.
- R2: A battery that is present before the supply has ever been within tolerance puts the block in the sealed state. While sealed, `sealed` is 1 and `pwr_sel` selects neither battery. The seal is cleared the first time the synchronized supply flag is high, and it never returns.
- R3: In normal operation with no inhibit armed, `ce_out_n` equals `ce_in_n` in the same cycle, with no clock latency.
- R4: If the synchronized chip-enable is low when the synchronized supply flag falls, `ce_out_n` keeps following `ce_in_n` until the input is seen high. After that, `ce_out_n` stays high for the rest of the failure.
- R5: If chip-enable is high when the failure is detected, `ce_out_n` is high from that clock edge onward until recovery ends.
- R6: After the synchronized supply flag returns, `ce_out_n` stays high for REC_CYCLES clocks. The recovery restarts if the supply fails again during that time.
- R7: If the stronger present battery reads low when the supply returns (no battery present also counts as low), then after recovery the second access is blocked: `ce_out_n` stays high for its whole duration. The first and third accesses pass. Accesses are separated by at least 4 idle cycles.
- R8: With a good battery, every access after recovery passes through.
- R9: `pwr_sel` is one-hot, with bit0 = main supply, bit1 = battery 1, bit2 = battery 2 and bit3 = none. The rules, in order:
  - The main supply is chosen whenever the supply-above-battery flag is set.
  - Otherwise, when not sealed, the stronger present battery is chosen: battery 1 when both are present and the stronger flag is 1.
  - Otherwise the sole present battery is chosen, or none.
  - The output updates one clock after the synchronized flags and keeps tracking during backup.
- R10: `tol_window` equals `tol_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in_n | input | 1 | Chip-enable from the decoder, active low |
| vcc_ok | input | 1 | Comparator: supply above the trip point |
| bat1_here | input | 1 | Battery 1 connected |
| bat2_here | input | 1 | Battery 2 connected |
| bat1_low | input | 1 | Battery 1 at or below the low threshold |
| bat2_low | input | 1 | Battery 2 at or below the low threshold |
| bat1_stronger | input | 1 | Battery 1 voltage above battery 2 |
| vcc_above_bat | input | 1 | Supply above the selected battery |
| tol_sel | input | 1 | Trip window select (0 = narrow, 1 = wide) |
| ce_out_n | output | 1 | Gated chip-enable to the RAM, active low |
| pwr_sel | output | 4 | One-hot power source select |
| sealed | output | 1 | Storage seal active |
| tol_window | output | 1 | Trip window select to the comparator |

## Verification
The hardest state to reach is a supply failure that lands while an access is active. A close second is the low-battery sequence, where the second access after recovery has to be suppressed. The stimulus first holds chip-enable low for several clocks, so the synchronized copy has settled, and only then drops the supply flag. It then releases and re-asserts chip-enable during the failure. For the low-battery case, the stimulus raises the stronger battery's low flag before the supply returns, waits out the full recovery count, and then issues three spaced accesses. A behavioural model compares all outputs on every clock.

// File: rtl/nvc_pkg.sv
`timescale 1ns/1ps
package nvc_pkg;

    typedef struct packed {
        logic ce_n;
        logic vgtb;
        logic b1str;
        logic b2low;
        logic b1low;
        logic b2p;
        logic b1p;
        logic vok;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    typedef enum logic [1:0] {MD_DOWN, MD_RECOVER, MD_RUN} mode_e;

    typedef enum logic [2:0] {
        IH_IDLE, IH_WAIT1, IH_IN1, IH_BLOCK, IH_BLKIN
    } inh_e;

    typedef enum logic [1:0] {SRC_MAIN, SRC_BAT1, SRC_BAT2, SRC_NONE} src_e;

    // Stronger of the present batteries; none when neither is present.
    function automatic src_e best_battery(flags_t f);
        if (f.b1p && f.b2p) return f.b1str ? SRC_BAT1 : SRC_BAT2;
        else if (f.b1p)     return SRC_BAT1;
        else if (f.b2p)     return SRC_BAT2;
        else                return SRC_NONE;
    endfunction

    // Low condition of the battery that would back the RAM.
    function automatic logic best_is_low(flags_t f);
        case (best_battery(f))
            SRC_BAT1: return f.b1low;
            SRC_BAT2: return f.b2low;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] src_onehot(src_e s);
        case (s)
            SRC_MAIN: return 4'b0001;
            SRC_BAT1: return 4'b0010;
            SRC_BAT2: return 4'b0100;
            default:  return 4'b1000;
        endcase
    endfunction

endpackage

// File: rtl/nvc_sync.sv
`timescale 1ns/1ps
module nvc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/nvc_supervisor.sv
`timescale 1ns/1ps
module nvc_supervisor
    import nvc_pkg::*;
#(
    parameter int REC_CYCLES = 1250000,
    parameter int CNT_W      = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1
) (
    input  logic   clk,
    input  logic   rst,
    input  flags_t f,
    output mode_e  mode,
    output logic   pass_hold,
    output logic   bat_low,
    output logic   sealed,
    output logic   seal_d,
    output logic   fail_evt,
    output logic   rec_done
);
    logic [CNT_W-1:0] rec_cnt;
    logic             ever_up;
    logic             rec_last;

    assign rec_last = (rec_cnt == CNT_W'(REC_CYCLES - 1));
    assign seal_d   = !(ever_up || f.vok) && (f.b1p || f.b2p);
    assign fail_evt = (mode != MD_DOWN) && !f.vok;
    assign rec_done = (mode == MD_RECOVER) && f.vok && rec_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MD_DOWN;
            rec_cnt   <= '0;
            pass_hold <= 1'b0;
            bat_low   <= 1'b0;
            ever_up   <= 1'b0;
            sealed    <= 1'b0;
        end else begin
            ever_up <= ever_up || f.vok;
            sealed  <= seal_d;
            case (mode)
                MD_DOWN: begin
                    if (f.vok) begin
                        mode      <= MD_RECOVER;
                        rec_cnt   <= '0;
                        bat_low   <= best_is_low(f);
                        pass_hold <= 1'b0;
                    end else if (f.ce_n) begin
                        pass_hold <= 1'b0;
                    end
                end
                MD_RECOVER: begin
                    if (!f.vok)        mode    <= MD_DOWN;
                    else if (rec_last) mode    <= MD_RUN;
                    else               rec_cnt <= rec_cnt + 1'b1;
                end
                MD_RUN: begin
                    if (!f.vok) begin
                        mode      <= MD_DOWN;
                        pass_hold <= !f.ce_n;
                    end
                end
                default: mode <= MD_DOWN;
            endcase
        end
    end
endmodule

// File: rtl/nvc_cycle_inhibit.sv
`timescale 1ns/1ps
module nvc_cycle_inhibit
    import nvc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  fail_evt,
    input  logic  rec_done,
    input  logic  bat_low,
    input  logic  ce_s,
    output inh_e  inh_state,
    output logic  block
);
    logic ce_prev;
    logic fall, rise;

    assign fall  = ce_prev && !ce_s;
    assign rise  = !ce_prev && ce_s;
    assign block = (inh_state == IH_BLOCK) || (inh_state == IH_BLKIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            inh_state <= IH_IDLE;
            ce_prev   <= 1'b1;
        end else begin
            ce_prev <= ce_s;
            if (fail_evt) begin
                inh_state <= IH_IDLE;
            end else if (rec_done) begin
                inh_state <= bat_low ? IH_WAIT1 : IH_IDLE;
            end else if (mode == MD_RUN) begin
                case (inh_state)
                    IH_WAIT1: if (fall) inh_state <= IH_IN1;
                    IH_IN1:   if (rise) inh_state <= IH_BLOCK;
                    IH_BLOCK: if (fall) inh_state <= IH_BLKIN;
                    IH_BLKIN: if (rise) inh_state <= IH_IDLE;
                    default:  inh_state <= IH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/nvc_src_select.sv
`timescale 1ns/1ps
module nvc_src_select
    import nvc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flags_t     f,
    input  logic       seal_d,
    output logic [3:0] pwr_sel
);
    src_e src_q, src_d;

    always_comb begin
        if (f.vgtb)      src_d = SRC_MAIN;
        else if (seal_d) src_d = SRC_NONE;
        else             src_d = best_battery(f);
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_NONE;
        else     src_q <= src_d;
    end

    assign pwr_sel = src_onehot(src_q);
endmodule

// File: rtl/nvc_ce_guard.sv
`timescale 1ns/1ps
module nvc_ce_guard
    import nvc_pkg::*;
#(
    parameter int REC_CYCLES  = 1250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_in_n,
    input  logic       vcc_ok,
    input  logic       bat1_here,
    input  logic       bat2_here,
    input  logic       bat1_low,
    input  logic       bat2_low,
    input  logic       bat1_stronger,
    input  logic       vcc_above_bat,
    input  logic       tol_sel,
    output logic       ce_out_n,
    output logic [3:0] pwr_sel,
    output logic       sealed,
    output logic       tol_window
);
    flags_t raw_f, sync_f;
    logic [FLAG_W-1:0] sync_vec;
    mode_e mode;
    inh_e  inh_state;
    logic  pass_hold, bat_low, seal_d, fail_evt, rec_done, inh_block;
    logic  lock;

    always_comb begin
        raw_f.ce_n  = ce_in_n;
        raw_f.vgtb  = vcc_above_bat;
        raw_f.b1str = bat1_stronger;
        raw_f.b2low = bat2_low;
        raw_f.b1low = bat1_low;
        raw_f.b2p   = bat2_here;
        raw_f.b1p   = bat1_here;
        raw_f.vok   = vcc_ok;
    end

    nvc_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d(raw_f), .q(sync_vec)
    );
    assign sync_f = flags_t'(sync_vec);

    nvc_supervisor #(.REC_CYCLES(REC_CYCLES)) i_sup (
        .clk(clk), .rst(rst), .f(sync_f), .mode(mode),
        .pass_hold(pass_hold), .bat_low(bat_low), .sealed(sealed),
        .seal_d(seal_d), .fail_evt(fail_evt), .rec_done(rec_done)
    );

    nvc_cycle_inhibit i_inh (
        .clk(clk), .rst(rst), .mode(mode), .fail_evt(fail_evt),
        .rec_done(rec_done), .bat_low(bat_low), .ce_s(sync_f.ce_n),
        .inh_state(inh_state), .block(inh_block)
    );

    nvc_src_select i_src (
        .clk(clk), .rst(rst), .f(sync_f), .seal_d(seal_d), .pwr_sel(pwr_sel)
    );

    // Chip-enable path stays combinational; only the lock is clocked.
    assign lock       = ((mode != MD_RUN) && !pass_hold) || inh_block;
    assign ce_out_n   = ce_in_n | lock;
    assign tol_window = tol_sel;
endmodule

// File: rtl/nvc_ce_guard_chk.sv
`timescale 1ns/1ps
module nvc_ce_guard_chk
    import nvc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ce_in_n,
    input logic       ce_out_n,
    input logic [3:0] pwr_sel,
    input logic       sealed,
    input mode_e      mode,
    input logic       pass_hold,
    input inh_e       inh_state
);
    logic seal_gone;

    always_ff @(posedge clk) begin
        if (rst)         seal_gone <= 1'b0;
        else if (sealed) seal_gone <= seal_gone;
        else if ($past(sealed)) seal_gone <= 1'b1;
    end

    a_r9_onehot_select: assert property (@(posedge clk) disable iff (rst)
        $countones(pwr_sel) == 1);

    a_r2_sealed_isolated: assert property (@(posedge clk) disable iff (rst)
        sealed |-> (!pwr_sel[1] && !pwr_sel[2]));

    a_r2_seal_never_returns: assert property (@(posedge clk) disable iff (rst)
        seal_gone |-> !sealed);

    a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_RUN && inh_state == IH_IDLE) |-> (ce_out_n == ce_in_n));

    a_r4_hold_only_in_failure: assert property (@(posedge clk) disable iff (rst)
        pass_hold |-> (mode == MD_DOWN));

    a_r5_locked_in_failure: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_DOWN && !pass_hold) |-> ce_out_n);

    a_r6_locked_in_recovery: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_RECOVER) |-> ce_out_n);

    a_r7_blocked_access: assert property (@(posedge clk) disable iff (rst)
        (inh_state == IH_BLOCK || inh_state == IH_BLKIN) |-> (ce_out_n && mode == MD_RUN));
endmodule

bind nvc_ce_guard nvc_ce_guard_chk i_chk (
    .clk(clk), .rst(rst), .ce_in_n(ce_in_n), .ce_out_n(ce_out_n),
    .pwr_sel(pwr_sel), .sealed(sealed), .mode(mode),
    .pass_hold(pass_hold), .inh_state(inh_state)
);

// File: tb/test_nvc_ce_guard.sv
`timescale 1ns/1ps
module test_nvc_ce_guard;
    localparam int REC = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_in_n = 1'b1, vcc_ok = 1'b0, bat1_here = 1'b0, bat2_here = 1'b0;
    logic bat1_low = 1'b0, bat2_low = 1'b0, bat1_stronger = 1'b0;
    logic vcc_above_bat = 1'b0, tol_sel = 1'b0;
    logic ce_out_n, sealed, tol_window;
    logic [3:0] pwr_sel;

    int checks = 0;
    int errors = 0;
    bit running = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    nvc_ce_guard #(.REC_CYCLES(REC)) i_nvc_ce_guard (
        .clk(clk), .rst(rst), .ce_in_n(ce_in_n), .vcc_ok(vcc_ok),
        .bat1_here(bat1_here), .bat2_here(bat2_here), .bat1_low(bat1_low),
        .bat2_low(bat2_low), .bat1_stronger(bat1_stronger),
        .vcc_above_bat(vcc_above_bat), .tol_sel(tol_sel),
        .ce_out_n(ce_out_n), .pwr_sel(pwr_sel), .sealed(sealed),
        .tol_window(tol_window)
    );

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // delay lines for the raw flags (two stages each)
    logic [7:0] q1, q2;
    bit   m_cep, m_hold, m_low, m_up, m_seal;
    int   m_mode;  // 0 failed, 1 recovering, 2 running
    int   m_cnt, m_inh, m_sel;

    function automatic int pick_bat(logic p1, logic p2, logic str);
        if (p1 && p2) return str ? 1 : 2;
        if (p1) return 1;
        if (p2) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        logic vok, b1p, b2p, b1l, b2l, str, vgt, ce;
        bit fail, done, fall, rise, blow;
        int bb;
        if (rst) begin
            q1 = '0; q2 = '0; m_cep = 1; m_hold = 0; m_low = 0; m_up = 0;
            m_seal = 0; m_mode = 0; m_cnt = 0; m_inh = 0; m_sel = 3;
        end else begin
            {ce, vgt, str, b2l, b1l, b2p, b1p, vok} = q2;
            fall = m_cep && !ce;
            rise = !m_cep && ce;
            fail = (m_mode != 0) && !vok;
            done = (m_mode == 1) && vok && (m_cnt == REC - 1);
            bb   = pick_bat(b1p, b2p, str);
            blow = (bb == 1) ? b1l : (bb == 2) ? b2l : 1'b1;
            m_seal = !(m_up || vok) && (b1p || b2p);
            m_up   = m_up || vok;
            m_sel  = vgt ? 0 : (m_seal ? 3 : bb);
            if (fail) m_inh = 0;
            else if (done) m_inh = m_low ? 1 : 0;
            else if (m_mode == 2) begin
                if      (m_inh == 1 && fall) m_inh = 2;
                else if (m_inh == 2 && rise) m_inh = 3;
                else if (m_inh == 3 && fall) m_inh = 4;
                else if (m_inh == 4 && rise) m_inh = 0;
            end
            if (m_mode == 0) begin
                if (vok || ce) m_hold = 0;
                if (vok) begin m_low = blow; m_mode = 1; m_cnt = 0; end
            end else if (m_mode == 1) begin
                if (!vok) m_mode = 0;
                else if (m_cnt == REC - 1) m_mode = 2;
                else m_cnt++;
            end else if (!vok) begin
                m_mode = 0; m_hold = !ce;
            end
            m_cep = ce;
            q2 = q1;
            q1 = {ce_in_n, vcc_above_bat, bat1_stronger, bat2_low, bat1_low,
                  bat2_here, bat1_here, vcc_ok};
        end
    end

    always @(negedge clk) begin
        bit blk;
        if (running && !rst) begin
            blk = ((m_mode != 2) && !m_hold) || m_inh == 3 || m_inh == 4;
            chk(cur_req, {3'b0, ce_out_n}, {3'b0, ce_in_n | blk});
            chk("R9", pwr_sel, 4'b0001 << m_sel);
            chk("R2", {3'b0, sealed}, {3'b0, m_seal});
            chk("R10", {3'b0, tol_window}, {3'b0, tol_sel});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic access(logic exp_out, string req);
        ce_in_n = 1'b0;
        tick(3);
        @(negedge clk);
        chk(req, {3'b0, ce_out_n}, {3'b0, exp_out});
        tick(3);
        ce_in_n = 1'b1;
        tick(8);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        running = 1;
        @(negedge clk);
        chk("R1", {3'b0, ce_out_n}, 4'b0001);
        chk("R1", pwr_sel, 4'b1000);
        chk("R1", {3'b0, sealed}, 4'b0000);
        tick(1);

        cur_req = "R2";
        bat1_here = 1'b1;
        tick(5);
        @(negedge clk);
        chk("R2", {3'b0, sealed}, 4'b0001);
        chk("R2", pwr_sel, 4'b1000);
        tick(1);
        bat2_here = 1'b1;
        tick(5);
        @(negedge clk);
        chk("R2", pwr_sel, 4'b1000);
        tick(1);

        cur_req = "R6";
        vcc_ok = 1'b1; vcc_above_bat = 1'b1;
        tick(6);
        @(negedge clk);
        chk("R2", {3'b0, sealed}, 4'b0000);
        chk("R9", pwr_sel, 4'b0001);
        tick(1);
        ce_in_n = 1'b0;
        tick(3);
        @(negedge clk);
        chk("R6", {3'b0, ce_out_n}, 4'b0001);
        tick(1);
        ce_in_n = 1'b1;
        tick(REC + 5);

        cur_req = "R8";
        access(1'b0, "R8"); access(1'b0, "R8"); access(1'b0, "R8");

        cur_req = "R3";
        for (int k = 0; k < 6; k++) begin
            ce_in_n = k[0];
            @(negedge clk);
            chk("R3", {3'b0, ce_out_n}, {3'b0, ce_in_n});
            tick(1);
        end
        ce_in_n = 1'b1;
        tick(8);

        cur_req = "R5";
        vcc_ok = 1'b0;
        tick(5);
        ce_in_n = 1'b0;
        tick(2);
        @(negedge clk);
        chk("R5", {3'b0, ce_out_n}, 4'b0001);
        chk("R9", pwr_sel, 4'b0001);
        tick(1);
        vcc_above_bat = 1'b0;
        tick(4);
        @(negedge clk);
        chk("R9", pwr_sel, 4'b0100);
        tick(1);
        bat1_stronger = 1'b1;
        tick(4);
        @(negedge clk);
        chk("R9", pwr_sel, 4'b0010);
        chk("R2", {3'b0, sealed}, 4'b0000);
        tick(1);
        bat1_here = 1'b0;
        tick(4);
        @(negedge clk);
        chk("R9", pwr_sel, 4'b0100);
        tick(1);
        bat1_here = 1'b1;
        ce_in_n = 1'b1;
        tick(4);

        cur_req = "R7";
        bat1_low = 1'b1;
        vcc_above_bat = 1'b1; vcc_ok = 1'b1;
        tick(REC + 8);
        access(1'b0, "R7"); access(1'b1, "R7"); access(1'b0, "R7");
        bat1_low = 1'b0;

        cur_req = "R4";
        ce_in_n = 1'b0;
        tick(4);
        vcc_ok = 1'b0;
        tick(6);
        @(negedge clk);
        chk("R4", {3'b0, ce_out_n}, 4'b0000);
        tick(1);
        ce_in_n = 1'b1;
        @(negedge clk);
        chk("R4", {3'b0, ce_out_n}, 4'b0001);
        tick(4);
        ce_in_n = 1'b0;
        tick(2);
        @(negedge clk);
        chk("R4", {3'b0, ce_out_n}, 4'b0001);
        tick(1);
        ce_in_n = 1'b1;
        tick(3);

        cur_req = "R8";
        vcc_ok = 1'b1;
        tick(REC + 8);
        access(1'b0, "R8"); access(1'b0, "R8"); access(1'b0, "R8");

        cur_req = "R10";
        tol_sel = 1'b1;
        @(negedge clk);
        chk("R10", {3'b0, tol_window}, 4'b0001);
        tick(1);
        tol_sel = 1'b0;
        @(negedge clk);
        chk("R10", {3'b0, tol_window}, 4'b0000);
        tick(2);

        running = 0;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule